// File: doc/BRIEF.md
# Prioritized Audio Receive Error Latch

This block sits behind the decoder of a digital audio receiver. It collects the individual error strobes that the decoder raises, along with the received validity bit and the lock state of the clock recovery loop. From them it produces three results. The first is a per-sample error flag for the sample that the serial port is shifting out. The second is a flag that combines validity and error, which interpolation filters use to conceal bad samples. The third is a 3-bit error code. The code is sticky: it keeps the most severe error seen since the last clear, not the latest one.

A single select input has two jobs. When it is high, the six shared status pins show channel status bits. When it is low, the same pins show the latched error code and a 3-bit frequency code. Holding select high for more than a set number of master clock cycles clears the latched code once. Returning select to low makes the freshly cleared code visible on the pins.

Top module: `audio_err_latch`

## Requirements
- R1: `err_flag` rises on the clock edge that samples a `parity_err` or `biphase_err` strobe. It stays high until the next `word_start` edge. At that edge it is reloaded with the parity/biphase strobes present in that same cycle.
- R2: While `unlock` is high, `err_flag` is high in the same cycle, with no register delay.
- R3: `vld_err_flag` is the OR of `valid_bit` and `err_flag`, in the same cycle.
- R4: Error codes in rising severity: 0 none, 1 validity (`valid_bit`), 2 slip, 3 confidence, 4 biphase, 5 parity, 6 unlock. With several sources active together, the most severe one is recorded.
- R5: The latched code after an edge is the larger of its old value and the code active in that cycle. A less severe error never replaces a more severe one.
- R6: The code clears on the 9th consecutive clock edge that samples `sel` high. Eight consecutive high edges followed by a low one leave the code unchanged.
- R7: The clear happens only once per high period of `sel`. Errors recorded after it, while `sel` stays high, are kept.
- R8: An error strobe sampled in the clear cycle is kept. The code after that edge equals that error's code, not 0.
- R9: With `sel` high, `shared_pins` equals `cs_bits`. With `sel` low, `shared_pins[2:0]` is the latched code and `shared_pins[5:3]` is `freq_code`.
- R10: After synchronous reset, the latched code is 0, `err_flag` is 0 and the select hold count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| word_start | input | 1 | Marks the first cycle of a new output sample |
| valid_bit | input | 1 | Received validity bit of the current sample |
| slip_err | input | 1 | Sample slip strobe |
| conf_err | input | 1 | Data confidence error strobe |
| biphase_err | input | 1 | Biphase coding violation strobe |
| parity_err | input | 1 | Parity error strobe |
| unlock | input | 1 | Clock recovery loop out of lock (level) |
| sel | input | 1 | Pin function select and clear request |
| cs_bits | input | 6 | Channel status bits shown when select is high |
| freq_code | input | 3 | Frequency code shown when select is low |
| err_flag | output | 1 | Per-sample error flag |
| vld_err_flag | output | 1 | Validity OR error flag |
| shared_pins | output | 6 | Shared status pins |

## Verification
The bench sweeps every ordered pair of error codes, including "none", through the latch. This catches a latch that keeps the latest error rather than the worst one, or one that drops a lower code after a higher one. It tests select hold lengths of exactly eight and nine cycles, which exposes an off-by-one clear threshold. A long hold with an error injected after the clear catches a clear that repeats every cycle. An error in the clear cycle itself catches a latch that would be left empty while an error is present. The per-sample flag is checked across sample boundaries, which shows whether it clears too early or never reloads.

// File: rtl/audio_err_pkg.sv
package audio_err_pkg;

    localparam int CODE_W = 3;
    localparam int PIN_W  = 6;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE    = 3'd0,
        ERR_VALID   = 3'd1,
        ERR_SLIP    = 3'd2,
        ERR_CONF    = 3'd3,
        ERR_BIPHASE = 3'd4,
        ERR_PARITY  = 3'd5,
        ERR_UNLOCK  = 3'd6
    } err_code_e;

    typedef struct packed {
        logic unlock;
        logic parity;
        logic biphase;
        logic conf;
        logic slip;
        logic valid;
    } err_src_t;

    // most severe active source wins
    function automatic err_code_e rank_errors(err_src_t s);
        if (s.unlock)       return ERR_UNLOCK;
        else if (s.parity)  return ERR_PARITY;
        else if (s.biphase) return ERR_BIPHASE;
        else if (s.conf)    return ERR_CONF;
        else if (s.slip)    return ERR_SLIP;
        else if (s.valid)   return ERR_VALID;
        else                return ERR_NONE;
    endfunction

    function automatic err_code_e worse_of(err_code_e a, err_code_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sel_clear_timer.sv
module sel_clear_timer #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic clr_pulse
);
    localparam int CNT_MAX = HOLD + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] hold_cnt;

    // fires on the high edge that pushes the count past HOLD
    assign clr_pulse = sel && (hold_cnt == CNT_W'(HOLD));

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CNT_W'(CNT_MAX)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sample_err_flag.sv
module sample_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic word_start,
    input  logic parity,
    input  logic biphase,
    input  logic unlock,
    output logic flag
);
    logic coding_err;
    logic sample_err_q;

    assign coding_err = parity | biphase;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_err_q <= 1'b0;
        end else if (word_start) begin
            sample_err_q <= coding_err;
        end else begin
            sample_err_q <= sample_err_q | coding_err;
        end
    end

    // loss of lock taints the sample at once
    assign flag = sample_err_q | unlock;
endmodule

// File: rtl/err_prio_latch.sv
module err_prio_latch
    import audio_err_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_src_t  src,
    input  logic      clr,
    output err_code_e code
);
    err_code_e now_code;
    err_code_e code_q;

    assign now_code = rank_errors(src);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= ERR_NONE;
        end else if (clr) begin
            code_q <= now_code;
        end else begin
            code_q <= worse_of(code_q, now_code);
        end
    end

    assign code = code_q;
endmodule

// File: rtl/audio_err_latch.sv
module audio_err_latch
    import audio_err_pkg::*;
#(
    parameter int CLR_HOLD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_start,
    input  logic             valid_bit,
    input  logic             slip_err,
    input  logic             conf_err,
    input  logic             biphase_err,
    input  logic             parity_err,
    input  logic             unlock,
    input  logic             sel,
    input  logic [PIN_W-1:0] cs_bits,
    input  logic [2:0]       freq_code,
    output logic             err_flag,
    output logic             vld_err_flag,
    output logic [PIN_W-1:0] shared_pins
);
    localparam int FREQ_W = PIN_W - CODE_W;

    err_src_t  src;
    err_code_e code_q;
    logic      clr_pulse;
    logic      flag_int;

    assign src = '{unlock:  unlock,
                   parity:  parity_err,
                   biphase: biphase_err,
                   conf:    conf_err,
                   slip:    slip_err,
                   valid:   valid_bit};

    sel_clear_timer #(.HOLD(CLR_HOLD)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .clr_pulse (clr_pulse)
    );

    sample_err_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .word_start (word_start),
        .parity     (parity_err),
        .biphase    (biphase_err),
        .unlock     (unlock),
        .flag       (flag_int)
    );

    err_prio_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .src  (src),
        .clr  (clr_pulse),
        .code (code_q)
    );

    assign err_flag     = flag_int;
    assign vld_err_flag = flag_int | valid_bit;

    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_pin
            if (i < CODE_W) begin : g_code
                assign shared_pins[i] = sel ? cs_bits[i] : code_q[i];
            end else begin : g_freq
                assign shared_pins[i] = sel ? cs_bits[i] : freq_code[i-CODE_W];
            end
        end
    endgenerate

    initial begin
        if (FREQ_W != 3) $error("frequency field width mismatch");
    end
endmodule

// File: rtl/audio_err_latch_chk.sv
module audio_err_latch_chk
    import audio_err_pkg::*;
#(
    parameter int CLR_HOLD = 8
) (
    input logic      clk,
    input logic      rst,
    input logic      sel,
    input logic      word_start,
    input logic      valid_bit,
    input logic      slip_err,
    input logic      conf_err,
    input logic      biphase_err,
    input logic      parity_err,
    input logic      unlock,
    input logic      err_flag,
    input logic      vld_err_flag,
    input err_code_e code_q
);
    logic [7:0] hi_cnt;
    err_src_t   s;

    assign s = '{unlock: unlock, parity: parity_err, biphase: biphase_err,
                 conf: conf_err, slip: slip_err, valid: valid_bit};

    always_ff @(posedge clk) begin
        if (rst || !sel) hi_cnt <= '0;
        else if (hi_cnt != 8'hff) hi_cnt <= hi_cnt + 1'b1;
    end

    // R1
    a_r1_coding_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (parity_err || biphase_err) |=> err_flag);

    // R2
    a_r2_unlock_flag: assert property (@(posedge clk) disable iff (rst)
        unlock |-> err_flag);

    // R3
    a_r3_flag_in_combined: assert property (@(posedge clk) disable iff (rst)
        (err_flag || valid_bit) |-> vld_err_flag);

    // R5 / R8
    a_r5_code_keeps_worst: assert property (@(posedge clk) disable iff (rst)
        (rank_errors(s) != ERR_NONE) |=> (code_q >= $past(rank_errors(s))));

    // R6 / R7
    a_r6_drop_only_on_clear: assert property (@(posedge clk) disable iff (rst)
        (code_q < $past(code_q)) |-> ($past(sel) && $past(hi_cnt) == 8'(CLR_HOLD)));

    // R10
    a_r10_reset_clean: assert property (@(posedge clk)
        $past(rst) && rst |-> (code_q == ERR_NONE));

    logic unused_ok;
    assign unused_ok = word_start;
endmodule

bind audio_err_latch audio_err_latch_chk #(.CLR_HOLD(CLR_HOLD)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel          (sel),
    .word_start   (word_start),
    .valid_bit    (valid_bit),
    .slip_err     (slip_err),
    .conf_err     (conf_err),
    .biphase_err  (biphase_err),
    .parity_err   (parity_err),
    .unlock       (unlock),
    .err_flag     (err_flag),
    .vld_err_flag (vld_err_flag),
    .code_q       (code_q)
);

// File: tb/audio_err_latch_bench.sv
module audio_err_latch_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_start = 0, valid_bit = 0, slip_err = 0, conf_err = 0;
    logic       biphase_err = 0, parity_err = 0, unlock = 0, sel = 0;
    logic [5:0] cs_bits = 6'h2a;
    logic [2:0] freq_code = 3'd3;
    logic       err_flag, vld_err_flag;
    logic [5:0] shared_pins;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    audio_err_latch u_audio_err_latch (
        .clk(clk), .rst(rst), .word_start(word_start), .valid_bit(valid_bit),
        .slip_err(slip_err), .conf_err(conf_err), .biphase_err(biphase_err),
        .parity_err(parity_err), .unlock(unlock), .sel(sel),
        .cs_bits(cs_bits), .freq_code(freq_code), .err_flag(err_flag),
        .vld_err_flag(vld_err_flag), .shared_pins(shared_pins)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: edge samples current inputs, return at the following negedge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(input int c);
        valid_bit = (c == 1); slip_err = (c == 2); conf_err = (c == 3);
        biphase_err = (c == 4); parity_err = (c == 5); unlock = (c == 6);
    endtask

    task automatic pulse_code(input int c);
        set_src(c); cyc(); set_src(0);
    endtask

    task automatic do_clear();
        sel = 1; repeat (9) cyc(); sel = 0; cyc();
    endtask

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        chk("R10 code after reset", {3'b0, shared_pins[2:0]}, 6'd0);
        chk("R10 flag after reset", {5'b0, err_flag}, 6'd0);
        rst = 0;
        cyc();

        // R4/R5/R9: every ordered pair of codes
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                do_clear();
                freq_code = 3'(a ^ b);
                pulse_code(a);
                chk("R4 single code", {3'b0, shared_pins[2:0]}, 6'(a));
                pulse_code(b);
                cyc();
                chk("R5 worst of pair", {3'b0, shared_pins[2:0]}, 6'((a > b) ? a : b));
                chk("R9 freq field", {3'b0, shared_pins[5:3]}, 6'(a ^ b));
            end
        end

        // R4: simultaneous sources
        do_clear();
        slip_err = 1; biphase_err = 1; valid_bit = 1; cyc(); set_src(0);
        chk("R4 simultaneous sources", {3'b0, shared_pins[2:0]}, 6'd4);

        // R6: eight high cycles do not clear
        do_clear(); pulse_code(5);
        sel = 1; repeat (8) cyc();
        chk("R9 status shown while sel high", shared_pins, 6'h2a);
        sel = 0; cyc();
        chk("R6 no clear after 8", {3'b0, shared_pins[2:0]}, 6'd5);
        sel = 1; repeat (9) cyc(); sel = 0; cyc();
        chk("R6 clear after 9", {3'b0, shared_pins[2:0]}, 6'd0);

        // R8: error in the clear cycle survives
        pulse_code(3);
        sel = 1; repeat (8) cyc();
        slip_err = 1; cyc(); slip_err = 0;
        sel = 0; cyc();
        chk("R8 error in clear cycle kept", {3'b0, shared_pins[2:0]}, 6'd2);

        // R7: clear not repeated during a long hold
        pulse_code(4);
        sel = 1; repeat (11) cyc();
        pulse_code(5);
        repeat (6) cyc();
        sel = 0; cyc();
        chk("R7 error after clear kept", {3'b0, shared_pins[2:0]}, 6'd5);

        // R1: per-sample flag
        word_start = 1; cyc(); word_start = 0;
        chk("R1 flag clear at sample start", {5'b0, err_flag}, 6'd0);
        cyc();
        parity_err = 1; cyc(); parity_err = 0;
        chk("R1 flag after parity", {5'b0, err_flag}, 6'd1);
        repeat (3) cyc();
        chk("R1 flag held in sample", {5'b0, err_flag}, 6'd1);
        word_start = 1; cyc(); word_start = 0;
        chk("R1 flag cleared at next sample", {5'b0, err_flag}, 6'd0);
        word_start = 1; biphase_err = 1; cyc(); word_start = 0; biphase_err = 0;
        chk("R1 flag reloaded at boundary", {5'b0, err_flag}, 6'd1);
        word_start = 1; cyc(); word_start = 0;

        // R3: combined flag
        valid_bit = 0; #1;
        chk("R3 none", {5'b0, vld_err_flag}, 6'd0);
        valid_bit = 1; #1;
        chk("R3 validity only", {5'b0, vld_err_flag}, 6'd1);
        valid_bit = 0;
        cyc();

        // R2: unlock is immediate
        unlock = 1; #1;
        chk("R2 unlock same cycle", {5'b0, err_flag}, 6'd1);
        chk("R3 error only", {5'b0, vld_err_flag}, 6'd1);
        cyc(); unlock = 0; #1;
        chk("R2 flag drops with lock", {5'b0, err_flag}, 6'd0);
        chk("R4 unlock code", {3'b0, shared_pins[2:0]}, 6'd6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R10 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule